// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This block keeps an interrupt-enable register and an interrupt-status register for each of several localities, and drives one shared level interrupt line. Other blocks send one-cycle event pulses, each aimed at a locality and carrying a cause vector. The causes are data available, status valid, locality changed and command ready. An event records a sticky status bit only when that locality has both its global enable and the enable for that cause set. The same event raises the interrupt line.

Software reaches the registers through a simple register port, which carries a locality index, a register select, byte enables and write data. Reads are combinational and return the copy held for the addressed locality. Writes to the enable or status registers take effect only when the addressed locality is the active one. Status bits are cleared by writing ones. The line falls only when such a clear leaves the writing locality's status at zero. The vector register is fixed by a parameter and cannot be written.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset every locality's enable register reads 0x0000_0008, which is polarity field bits[4:3] = 01, meaning low level. Every status register reads 0 and `irq` is 0.
- R2: An event sets status bits in its target locality only where the cause is present, that locality's enable bit 31 is 1 and the matching enable bit is 1. The cause mapping is `evt_cause[0]` to bit 0 (data available), `evt_cause[1]` to bit 1 (status valid), `evt_cause[2]` to bit 2 (locality changed) and `evt_cause[3]` to bit 7 (command ready). When any bit is recorded, `irq` is 1 from the next cycle.
- R3: An event whose `evt_loc` is NUM_LOC or greater changes no status register and does not raise `irq`.
- R4: An enable or status write is ignored when `reg_loc` differs from `active_loc`, or when `active_loc` is NUM_LOC or greater (no locality active).
- R5: An accepted enable write (`reg_sel` = 0) updates only the byte lanes selected by `reg_be`. Within those lanes it stores only the bits of mask 0x8000_009F. Every other bit reads 0.
- R6: An accepted status write (`reg_sel` = 1) clears the status bits where the write data has a 1, within the enabled byte lanes and the cause bits 0x87. No other status bit changes.
- R7: `irq` falls only after a status write that clears at least one set bit and leaves the writing locality's status at zero. Clearing some bits while others remain set keeps `irq` at 1.
- R8: Reads with `reg_sel` = 2 return IRQ_VECTOR, a value from 0 to 15, in bits[3:0]. Writes to it have no effect.
- R9: Reads return the enable (`reg_sel` = 0) or status (`reg_sel` = 1) copy of `reg_loc`, whichever locality is active. `reg_sel` = 3 and any `reg_loc` of NUM_LOC or greater read 0.
- R10: When an event and a status write hit the same bit of the same locality in one cycle, the bit ends up set and `irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_loc | input | LOC_W | Active locality index; NUM_LOC or greater means none |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_loc | input | LOC_W | Locality addressed by the access |
| reg_sel | input | 2 | 0 enable, 1 status, 2 vector, 3 unused |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| evt_valid | input | 1 | Event pulse |
| evt_loc | input | LOC_W | Target locality of the event |
| evt_cause | input | 4 | Cause vector of the event |
| irq | output | 1 | Shared interrupt line, active high |

## Verification
The bench aims at the gaps between gating conditions. It sends events with the cause enabled but the global enable off, which a design that ignores bit 31 would latch. It makes clears from a locality that is not active, which a design that checks only the addressed locality would accept. It writes with partial byte enables, which a design that ignores lane masking would store in full.

The line is tested after partial clears, where it must stay high. It is also tested after a clear that zeroes one locality while another still holds bits, where it must fall. Together these tests tell apart a design that ORs all status bits from one that tracks the line separately. A clear and an event on the same bit in one cycle show which of the two wins.

// File: rtl/loc_irq_unit.sv
module loc_irq_unit #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3,
  parameter logic [3:0] IRQ_VECTOR = 4'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic             reg_wr,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [1:0]       reg_sel,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             evt_valid,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_cause,
  output logic             irq
);
  localparam logic [31:0] CAUSE_BITS = 32'h0000_0087;
  localparam logic [31:0] EN_BITS    = 32'h8000_009F;
  localparam logic [31:0] EN_RESET   = 32'h0000_0008;
  localparam logic [LOC_W-1:0] LOC_LIMIT = LOC_W'(NUM_LOC);

  logic [NUM_LOC-1:0][31:0] en_q, st_q;
  logic [NUM_LOC-1:0] set_any, lower;
  logic [31:0] lane, cause_vec;
  logic wr_ok;

  assign lane      = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
  assign cause_vec = {24'b0, evt_cause[3], 4'b0, evt_cause[2:0]};
  assign wr_ok     = reg_wr && (active_loc < LOC_LIMIT) && (reg_loc == active_loc);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic [31:0] set_b, clr_b, st_nx;
    logic hit_wr;
    assign hit_wr = wr_ok && (reg_loc == LOC_W'(i));
    assign set_b  = (evt_valid && evt_loc == LOC_W'(i) && en_q[i][31]) ? (cause_vec & en_q[i]) : 32'b0;
    assign clr_b  = (hit_wr && reg_sel == 2'd1) ? (reg_wdata & lane & CAUSE_BITS) : 32'b0;
    assign st_nx  = (st_q[i] & ~clr_b) | set_b;
    assign set_any[i] = |set_b;
    assign lower[i]   = (|clr_b) && (|st_q[i]) && (st_nx == 32'b0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i] <= EN_RESET;
        st_q[i] <= 32'b0;
      end else begin
        st_q[i] <= st_nx;
        if (hit_wr && reg_sel == 2'd0)
          en_q[i] <= (en_q[i] & ~lane) | (reg_wdata & lane & EN_BITS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq <= 1'b0;
    else if (|set_any)   irq <= 1'b1;
    else if (|lower)     irq <= 1'b0;
  end

  always_comb begin
    reg_rdata = 32'b0;
    if (reg_loc < LOC_LIMIT) begin
      case (reg_sel)
        2'd0:    reg_rdata = en_q[reg_loc];
        2'd1:    reg_rdata = st_q[reg_loc];
        2'd2:    reg_rdata = {28'b0, IRQ_VECTOR};
        default: reg_rdata = 32'b0;
      endcase
    end
  end

  AST_IRQ_RISE_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_valid)); // R2
  AST_BAD_LOC_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_loc >= LOC_LIMIT && !reg_wr) |=> ($stable(st_q) && !$rose(irq))); // R3
  AST_INACTIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_loc != active_loc && !evt_valid) |=> ($stable(st_q) && $stable(en_q))); // R4
  AST_IRQ_FALL_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_ok && reg_sel == 2'd1)); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|st_q)); // R7
endmodule

// File: tb/test_loc_irq_unit.sv
module test_loc_irq_unit;
  logic clk = 0, rst_n = 0;
  logic [2:0] active_loc = 3'd7, reg_loc = 0, evt_loc = 0;
  logic reg_wr = 0, evt_valid = 0;
  logic [1:0] reg_sel = 0;
  logic [3:0] reg_be = 0, evt_cause = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic [31:0] m_en [5];
  logic [31:0] m_st [5];
  bit m_irq;

  always #10 clk = ~clk;

  loc_irq_unit i_loc_irq_unit (.clk(clk), .rst_n(rst_n), .active_loc(active_loc),
    .reg_wr(reg_wr), .reg_loc(reg_loc), .reg_sel(reg_sel), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_loc(evt_loc), .evt_cause(evt_cause), .irq(irq));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [2:0] loc, logic [1:0] sel);
    if (loc >= 5) return 32'b0;
    case (sel)
      2'd0: return m_en[loc];
      2'd1: return m_st[loc];
      2'd2: return 32'd5;
      default: return 32'b0;
    endcase
  endfunction

  task automatic rd(logic [2:0] loc, logic [1:0] sel, output logic [31:0] v);
    reg_loc = loc; reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic step(bit wr, logic [2:0] loc, logic [1:0] sel, logic [3:0] be,
                      logic [31:0] wd, bit ev, logic [2:0] eloc, logic [3:0] ec);
    logic [31:0] ns [5];
    logic [31:0] ne [5];
    logic [31:0] lane, set, clr;
    bit wok, s_any, low;
    @(negedge clk);
    reg_wr = wr; reg_loc = loc; reg_sel = sel; reg_be = be; reg_wdata = wd;
    evt_valid = ev; evt_loc = eloc; evt_cause = ec;
    lane = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    wok = wr && active_loc < 5 && loc == active_loc;
    s_any = 0; low = 0;
    for (int l = 0; l < 5; l++) begin
      set = 0; clr = 0;
      if (ev && eloc == 3'(l) && m_en[l][31])
        set = {24'b0, ec[3], 4'b0, ec[2:0]} & m_en[l];
      if (wok && sel == 2'd1 && loc == 3'(l)) clr = wd & lane & 32'h87;
      ns[l] = (m_st[l] & ~clr) | set;
      ne[l] = m_en[l];
      if (wok && sel == 2'd0 && loc == 3'(l))
        ne[l] = (m_en[l] & ~lane) | (wd & lane & 32'h8000_009F);
      if (set != 0) s_any = 1;
      if (clr != 0 && m_st[l] != 0 && ns[l] == 0) low = 1;
    end
    @(posedge clk); #1;
    for (int l = 0; l < 5; l++) begin m_st[l] = ns[l]; m_en[l] = ne[l]; end
    if (s_any) m_irq = 1; else if (low) m_irq = 0;
    reg_wr = 0; evt_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    for (int l = 0; l < 5; l++) begin m_en[l] = 32'h8; m_st[l] = 0; end
    m_irq = 0;
    #35 rst_n = 1;
    #2;
    for (int l = 0; l < 5; l++) begin
      rd(3'(l), 0, v); chk("R1 enable reset", v, 32'h8);
      rd(3'(l), 1, v); chk("R1 status reset", v, 0);
    end
    chk("R1 irq reset", {31'b0, irq}, 0);

    step(1, 0, 2, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, 2, v); chk("R8 vector", v, 32'd5);

    active_loc = 0;
    step(1, 0, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, 0, v); chk("R5 enable mask", v, 32'h8000_009F);
    step(1, 0, 0, 4'b0001, 32'h0, 0, 0, 0);
    rd(0, 0, v); chk("R5 byte lane", v, 32'h8000_0000);
    step(0, 0, 0, 0, 0, 1, 0, 4'hF);
    rd(0, 1, v); chk("R2 cause disabled", v, 0);
    chk("R2 irq quiet", {31'b0, irq}, 0);
    step(1, 0, 0, 4'b1000, 32'h0, 0, 0, 0);
    step(1, 0, 0, 4'b0001, 32'hFF, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 4'hF);
    rd(0, 1, v); chk("R2 global off", v, 0);
    step(1, 0, 0, 4'b1000, 32'h8000_0000, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 4'hF);
    rd(0, 1, v); chk("R2 all causes", v, 32'h87);
    chk("R2 irq raised", {31'b0, irq}, 1);

    step(1, 0, 1, 4'b0000, 32'h87, 0, 0, 0);
    rd(0, 1, v); chk("R6 no lanes", v, 32'h87);
    step(1, 0, 1, 4'hF, 32'hFFFF_FF01, 0, 0, 0);
    rd(0, 1, v); chk("R6 partial clear", v, 32'h86);
    chk("R7 irq held", {31'b0, irq}, 1);
    step(1, 0, 1, 4'hF, 32'h86, 0, 0, 0);
    rd(0, 1, v); chk("R6 full clear", v, 0);
    chk("R7 irq lowered", {31'b0, irq}, 0);

    step(0, 0, 0, 0, 0, 1, 0, 4'h1);
    active_loc = 1;
    step(1, 0, 1, 4'hF, 32'h1, 0, 0, 0);
    step(1, 0, 0, 4'hF, 32'h0, 0, 0, 0);
    rd(0, 1, v); chk("R4 inactive clear", v, 32'h1);
    rd(0, 0, v); chk("R9 read other locality", v, 32'h8000_009F);
    active_loc = 7;
    step(1, 0, 1, 4'hF, 32'h1, 0, 0, 0);
    rd(0, 1, v); chk("R4 none active", v, 32'h1);
    rd(6, 0, v); chk("R9 invalid locality", v, 0);
    rd(0, 3, v); chk("R9 unused select", v, 0);

    for (int e = 5; e < 8; e++) step(0, 0, 0, 0, 0, 1, 3'(e), 4'hF);
    for (int l = 0; l < 5; l++) begin
      rd(3'(l), 1, v); chk("R3 bad target", v, l == 0 ? 32'h1 : 32'h0);
    end

    active_loc = 0;
    step(1, 0, 1, 4'hF, 32'h1, 1, 0, 4'h1);
    rd(0, 1, v); chk("R10 set wins", v, 32'h1);
    chk("R10 irq", {31'b0, irq}, 1);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 5));
      active_loc = (a == 5) ? 3'd7 : a;
      step($urandom_range(0, 1) == 1,
           ($urandom_range(0, 3) != 0) ? active_loc : 3'($urandom),
           2'($urandom), 4'($urandom),
           ($urandom_range(0, 1) == 1) ? $urandom : 32'h8000_00FF,
           $urandom_range(0, 2) != 0, 3'($urandom_range(0, 6)), 4'($urandom));
      chk("R7 random irq", {31'b0, irq}, {31'b0, m_irq});
      a = 3'($urandom);
      rd(a, 2'($urandom), v);
      chk("R9 random read (R2 R5 R6)", v, exp_rd(a, reg_sel));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule